// File: doc/BRIEF.md
# Byte UART Core with Phase-Selected Interrupt

This block is the byte-level serial engine behind a small register file. Software writes a byte into a holding register. The byte moves into a shift register as soon as the shifter is idle and transmission is enabled. The shifter sends the byte as an 8N1 frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts sixteen pulses of an oversampling tick that an external baud generator supplies. The receiver watches the serial input, finds a start bit, and samples each bit near its centre. It places the completed byte in a receive register together with sticky error flags.

A single level-sensitive interrupt line is the OR of every status flag gated by its mask bit. Software steps through its transmit, transmit-complete and receive phases by reprogramming the mask:

- In the transmit phase, it enables the holding-register-empty source.
- In the transmit-complete phase, it enables the shifter-empty source.
- In the receive phase, it enables the receive-full and any-error sources.

Top module: `sirq_uart`

## Requirements
- R1: After a synchronous reset, the status register (address 1) reads 0x03, meaning holding register empty (bit 0) and shifter empty (bit 1). The serial output is high, and the interrupt line is low.
- R2: Control register (address 0) bit 0 enables transmission and bit 1 enables reception. A held byte is never sent while bit 0 is clear. A frame arriving while bit 1 is clear leaves the receive-full flag clear.
- R3: Writing control with bit 2 set discards the held byte and sets holding-empty, while the line stays idle. Bit 2 always reads back as 0.
- R4: Writing the transmit register (address 3) clears holding-empty in the next cycle. When transmission is enabled and the shifter is idle, the byte is loaded into the shifter one cycle later, which sets holding-empty and clears shifter-empty. The line then carries a start bit of 0, data bits 0 to 7, and a stop bit of 1, each lasting 16 ticks.
- R5: Shifter-empty sets on the tick that ends the stop bit. A transfer is complete only when status bits 0 and 1 are both set.
- R6: The receiver samples each bit on the eighth tick after start detection, and then every 16 ticks. After a good frame, receive-full (status bit 2) is set and the byte can be read at address 4.
- R7: A stop bit sampled low stores the byte and sets framing error (bit 4) and any-error (bit 6).
- R8: A byte that completes while receive-full is still set is discarded. The old byte is kept, and overrun (bit 5) and any-error (bit 6) are set.
- R9: A read access to address 4 clears receive-full and all receive error flags. The parity error flag (bit 3) always reads 0.
- R10: The error register (address 5) holds copies of status bits 6:3 in the same bit positions, set by the same events. Writing a 0 to a bit clears that bit, writing a 1 leaves it unchanged, and a receive data read does not affect this register.
- R11: The mask register (address 2) keeps bits 0, 1, 2 and 6, which enable holding-empty, shifter-empty, receive-full and any-error. The interrupt line is high exactly while some masked-in status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on address 4) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Level interrupt request |

## Verification
The transmit path is compared against a behavioural reference model on every clock, covering the serial line, the empty flags and the interrupt. It is driven with three patterns:

- A byte held while transmission is off, which separates a missing enable gate from a working one.
- A byte discarded by the clear bit.
- Two back-to-back bytes, where the second must wait in the holding register, which exposes wrong load timing or a lost byte.

Receive is tried with four patterns, each separating a different flag path:

- A clean frame.
- A frame whose stop bit is low.
- Two frames with no read in between, which exposes overrun handling.
- A frame sent with reception disabled.

// File: rtl/sirq_uart_pkg.sv
package sirq_uart_pkg;

    localparam int DW = 8;
    localparam int AW = 3;
    localparam logic [7:0] MASK_KEEP = 8'h47;

    typedef enum logic [AW-1:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_MASK = 3'd2,
        A_TXD  = 3'd3,
        A_RXD  = 3'd4,
        A_ERRS = 3'd5
    } reg_addr_e;

    localparam int CTL_TXEN  = 0;
    localparam int CTL_RXEN  = 1;
    localparam int CTL_TXCLR = 2;

    typedef struct packed {
        logic sum_err;
        logic ovr_err;
        logic frm_err;
        logic par_err;
        logic rx_full;
        logic tsr_empty;
        logic thr_empty;
    } stat_t;

    function automatic logic [7:0] stat_byte(stat_t s);
        return {1'b0, s};
    endfunction

endpackage

// File: rtl/sirq_uart_tx.sv
module sirq_uart_tx #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          busy,
    output logic          txd
);
    localparam int CW   = $clog2(OSR);
    localparam int BW   = $clog2(DW + 2);
    localparam int LAST = DW + 1;

    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic [DW-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            txd  <= 1'b1;
        end else if (load && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
            bitn <= '0;
            sh   <= load_data;
            txd  <= 1'b0;
        end else if (busy && tick) begin
            if (cnt == CW'(OSR - 1)) begin
                cnt <= '0;
                if (bitn == BW'(LAST)) begin
                    busy <= 1'b0;
                    txd  <= 1'b1;
                end else begin
                    bitn <= bitn + 1'b1;
                    if (bitn == BW'(DW)) begin
                        txd <= 1'b1;
                    end else begin
                        txd <= sh[0];
                        sh  <= sh >> 1;
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_idle_line_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

endmodule

// File: rtl/sirq_uart_rx.sv
module sirq_uart_rx #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic          rxd,
    output logic          done,
    output logic          frm_err,
    output logic [DW-1:0] data
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(DW + 2);
    localparam int MID = OSR / 2 - 1;

    logic          s1, s2, busy;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic [DW-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= 1'b1;
            s2      <= 1'b1;
            busy    <= 1'b0;
            cnt     <= '0;
            bitn    <= '0;
            sh      <= '0;
            done    <= 1'b0;
            frm_err <= 1'b0;
            data    <= '0;
        end else begin
            s1   <= rxd;
            s2   <= s1;
            done <= 1'b0;
            if (!busy) begin
                if (en && tick && !s2) begin
                    busy <= 1'b1;
                    cnt  <= '0;
                    bitn <= '0;
                end
            end else if (tick) begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(MID)) begin
                    if (bitn == '0) begin
                        if (s2) busy <= 1'b0;
                        else    bitn <= 1;
                    end else if (bitn == BW'(DW + 1)) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        frm_err <= !s2;
                        data    <= sh;
                    end else begin
                        sh   <= {s2, sh[DW-1:1]};
                        bitn <= bitn + 1'b1;
                    end
                end
            end
        end
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sirq_uart.sv
module sirq_uart
    import sirq_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick16,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic          rxd,
    output logic          txd,
    output logic          irq
);
    logic          txen_q, rxen_q, tbe_q, rbf_q, fre_q, ove_q, sme_q;
    logic [7:0]    mask_q;
    logic [DW-1:0] thr_q, rbr_q;
    logic [3:0]    errs_q;
    logic          tx_busy, tx_load;
    logic          rx_done, rx_ferr;
    logic [DW-1:0] rx_data;
    logic          wr_ctl, wr_txd, wr_msk, wr_errs, rd_rx;
    stat_t         st;
    logic [3:0]    err_ev;

    assign wr_ctl  = wr_en && (addr == A_CTRL);
    assign wr_txd  = wr_en && (addr == A_TXD);
    assign wr_msk  = wr_en && (addr == A_MASK);
    assign wr_errs = wr_en && (addr == A_ERRS);
    assign rd_rx   = rd_en && (addr == A_RXD);
    assign tx_load = txen_q && !tbe_q && !tx_busy;

    sirq_uart_tx #(.DW(DW), .OSR(OSR)) u_tx (
        .clk(clk), .rst(rst), .tick(tick16), .load(tx_load),
        .load_data(thr_q), .busy(tx_busy), .txd(txd)
    );

    sirq_uart_rx #(.DW(DW), .OSR(OSR)) u_rx (
        .clk(clk), .rst(rst), .tick(tick16), .en(rxen_q), .rxd(rxd),
        .done(rx_done), .frm_err(rx_ferr), .data(rx_data)
    );

    // error events in the bit order of status 6:3 (sum, overrun, framing, parity)
    always_comb begin
        err_ev = 4'b0000;
        if (rx_done) begin
            if (rbf_q)        err_ev = 4'b1100;
            else if (rx_ferr) err_ev = 4'b1010;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txen_q <= 1'b0;
            rxen_q <= 1'b0;
            tbe_q  <= 1'b1;
            thr_q  <= '0;
            mask_q <= '0;
            rbr_q  <= '0;
            rbf_q  <= 1'b0;
            fre_q  <= 1'b0;
            ove_q  <= 1'b0;
            sme_q  <= 1'b0;
            errs_q <= '0;
        end else begin
            if (wr_ctl) begin
                txen_q <= wdata[CTL_TXEN];
                rxen_q <= wdata[CTL_RXEN];
            end
            if (wr_msk) mask_q <= wdata & MASK_KEEP;
            if (wr_txd) begin
                thr_q <= wdata;
                tbe_q <= 1'b0;
            end else if (tx_load || (wr_ctl && wdata[CTL_TXCLR])) begin
                tbe_q <= 1'b1;
            end
            if (rx_done) begin
                if (rbf_q) begin
                    ove_q <= 1'b1;
                    sme_q <= 1'b1;
                end else begin
                    rbr_q <= rx_data;
                    rbf_q <= 1'b1;
                    if (rx_ferr) begin
                        fre_q <= 1'b1;
                        sme_q <= 1'b1;
                    end
                end
            end else if (rd_rx) begin
                rbf_q <= 1'b0;
                fre_q <= 1'b0;
                ove_q <= 1'b0;
                sme_q <= 1'b0;
            end
            errs_q <= (wr_errs ? (errs_q & wdata[6:3]) : errs_q) | err_ev;
        end
    end

    always_comb begin
        st.sum_err   = sme_q;
        st.ovr_err   = ove_q;
        st.frm_err   = fre_q;
        st.par_err   = 1'b0;
        st.rx_full   = rbf_q;
        st.tsr_empty = !tx_busy;
        st.thr_empty = tbe_q;
    end

    assign irq = |(stat_byte(st) & mask_q);

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {5'b0, 1'b0, rxen_q, txen_q};
            A_STAT:  rdata = stat_byte(st);
            A_MASK:  rdata = mask_q;
            A_TXD:   rdata = thr_q;
            A_RXD:   rdata = rbr_q;
            A_ERRS:  rdata = {1'b0, errs_q, 3'b000};
            default: rdata = 8'h00;
        endcase
    end

    p_wr_clears_tbe_r4: assert property (@(posedge clk) disable iff (rst)
        wr_txd |=> !st.thr_empty);
    p_load_sets_tbe_r4: assert property (@(posedge clk) disable iff (rst)
        tx_load && !wr_txd |=> st.thr_empty && !st.tsr_empty);
    p_tsbe_line_high_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st.tsr_empty) |-> txd);
    p_sum_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (fre_q || ove_q) |-> sme_q);
    p_overrun_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        rx_done && rbf_q |=> $stable(rbr_q) && ove_q && sme_q);
    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        rd_rx && !rx_done |=> !rbf_q && !fre_q && !ove_q && !sme_q);
    p_errs_hold_r10: assert property (@(posedge clk) disable iff (rst)
        rd_rx && !wr_errs && !rx_done |=> errs_q == $past(errs_q));
    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 8'h00) |-> !irq);

endmodule

// File: tb/tb_sirq_uart.sv
`timescale 1ns/1ps
module tb_sirq_uart;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;

    int checks = 0;
    int errors = 0;
    bit live = 0;

    sirq_uart dut (
        .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    always #4 clk = ~clk;

    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            tick16 = (cyc % 4 == 0);
            cyc++;
        end
    end

    // behavioural transmit reference model
    bit       m_txen, m_full, m_act;
    int       m_el;
    bit [7:0] m_hold, m_frame, m_mask;

    always @(posedge clk) begin
        if (rst) begin
            m_txen = 0; m_full = 0; m_act = 0; m_el = 0;
            m_hold = 0; m_frame = 0; m_mask = 0;
        end else begin
            bit ld;
            ld = m_txen && m_full && !m_act;
            if (m_act && tick16) begin
                m_el++;
                if (m_el == 160) m_act = 0;
            end
            if (ld) begin
                m_act = 1; m_el = 0; m_frame = m_hold;
            end
            if (wr_en && addr == 3'd3) begin
                m_full = 1; m_hold = wdata;
            end else if (ld || (wr_en && addr == 3'd0 && wdata[2])) begin
                m_full = 0;
            end
            if (wr_en && addr == 3'd0) m_txen = wdata[0];
            if (wr_en && addr == 3'd2) m_mask = wdata & 8'h47;
        end
    end

    function automatic bit exp_line();
        int idx;
        if (!m_act) return 1'b1;
        idx = m_el / 16;
        if (idx == 0) return 1'b0;
        if (idx >= 9) return 1'b1;
        return m_frame[idx-1];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live && !rst) begin
            chk("R4 line", {7'b0, txd}, {7'b0, exp_line()});
            if (!m_mask[2] && !m_mask[6])
                chk("R11 irq", {7'b0, irq},
                    {7'b0, (m_mask[0] & !m_full) | (m_mask[1] & !m_act)});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input bit pop, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = pop;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit stop_hi);
        @(negedge clk);
        rxd = 1'b0;
        repeat (64) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (64) @(negedge clk);
        end
        rxd = stop_hi;
        repeat (stop_hi ? 64 : 40) @(negedge clk);
        rxd = 1'b1;
        repeat (100) @(negedge clk);
    endtask

    initial begin
        #1200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        live = 1;
        rd(3'd1, 0, v);  chk("R1 status", v, 8'h03);
        chk("R1 line", {7'b0, txd}, 8'h01);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // transmit disabled: byte stays held
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h5A);
        repeat (100) @(negedge clk);
        rd(3'd1, 0, v);  chk("R2 held", v, 8'h02);
        wr(3'd0, 8'h04);
        rd(3'd1, 0, v);  chk("R3 cleared", v, 8'h03);
        rd(3'd0, 0, v);  chk("R3 clear bit reads 0", v, 8'h00);

        // transmit two bytes back to back
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h01);
        wr(3'd3, 8'hA5);
        repeat (3) @(negedge clk);
        wr(3'd3, 8'h3C);
        rd(3'd1, 0, v);  chk("R4 second held", v, 8'h00);
        chk("R11 irq off while held", {7'b0, irq}, 8'h00);
        repeat (1400) @(negedge clk);
        rd(3'd1, 0, v);  chk("R5 complete", v, 8'h03);
        wr(3'd2, 8'h02);
        @(negedge clk);
        chk("R11 shifter empty irq", {7'b0, irq}, 8'h01);

        // receive a clean frame
        wr(3'd0, 8'h02);
        wr(3'd2, 8'h04);
        send(8'hA5, 1);
        rd(3'd1, 0, v);  chk("R6 full", v, 8'h07);
        chk("R11 rx irq", {7'b0, irq}, 8'h01);
        rd(3'd4, 1, v);  chk("R6 data", v, 8'hA5);
        rd(3'd1, 0, v);  chk("R9 cleared", v, 8'h03);
        chk("R11 rx irq low", {7'b0, irq}, 8'h00);

        // framing error
        send(8'h81, 0);
        rd(3'd1, 0, v);  chk("R7 flags", v, 8'h57);
        rd(3'd5, 0, v);  chk("R10 mirror", v, 8'h50);
        rd(3'd4, 1, v);  chk("R7 data stored", v, 8'h81);
        rd(3'd1, 0, v);  chk("R9 errors cleared", v, 8'h03);
        rd(3'd5, 0, v);  chk("R10 unaffected by read", v, 8'h50);
        wr(3'd5, 8'hFF);
        rd(3'd5, 0, v);  chk("R10 write ones keep", v, 8'h50);
        wr(3'd5, 8'h00);
        rd(3'd5, 0, v);  chk("R10 write zero clears", v, 8'h00);

        // overrun
        send(8'h11, 1);
        send(8'h22, 1);
        rd(3'd1, 0, v);  chk("R8 flags", v, 8'h67);
        rd(3'd5, 0, v);  chk("R10 overrun mirror", v, 8'h60);
        wr(3'd2, 8'h40);
        @(negedge clk);
        chk("R11 sum irq", {7'b0, irq}, 8'h01);
        rd(3'd4, 1, v);  chk("R8 old data kept", v, 8'h11);
        rd(3'd1, 0, v);  chk("R9 overrun cleared", v, 8'h03);

        // reception disabled
        wr(3'd0, 8'h00);
        send(8'h77, 1);
        rd(3'd1, 0, v);  chk("R2 rx disabled", v, 8'h03);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule